// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block gives a test instrument serial access to a small group of digital I/O pins. The instrument uses a test clock, a mode-select input, serial data in and serial data out. A sixteen-state controller, advanced by the mode-select level at each rising test-clock edge, steps the block through instruction scans and data scans. A 4-bit instruction picks which register sits between serial in and serial out: a 32-bit identification word, a one-bit bypass stage, a one-bit device-reset stage, or a boundary chain that holds four cells for every pin.

During normal operation the pads simply follow the core's pull-up-disable, output-enable and output-data signals. With the external-test instruction active, the pads are driven instead from update latches that are written at the end of a data scan. Pin levels and the core's drive requests can be captured into the chain and read out. The block has no dedicated high-impedance instruction. Instead, shifting a 1 into the device-reset stage asserts the chip reset output, and while that output is high every pad output enable is forced low.

Top module: `tap_scan_ctrl`

## Requirements
- R1: Test reset (a high `trst` at a rising edge) or the Test-Logic-Reset state makes IDCODE (0x1) the active instruction. A data scan under IDCODE captures the 32-bit identity word and returns it least significant bit first: version in bits 31:28, part number in bits 27:12, manufacturer code in bits 11:1, and bit 0 always 1.
- R2: The controller follows the sixteen-state IEEE 1149.1 diagram, sampling `tms` on the rising edge of `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and a data scan through the Pause and Exit2 states continues without losing bits.
- R3: The instruction register is 4 bits wide. Capture-IR loads the binary value 0001, shifting moves least significant bit first from `tdi` towards `tdo`, and the new instruction becomes active at the rising edge that leaves Update-IR.
- R4: Opcode 0xF, and every opcode other than 0x0, 0x1 and 0xC, selects a one-bit bypass stage that captures 0. A bit shifted in therefore appears at `tdo` one shift later.
- R5: Opcode 0x0 (external test) selects a chain of 4×NPIN cells. Cell index 4p+c belongs to pin p, with c=0 pull-up disable, c=1 output enable, c=2 output data and c=3 input level. Cell 0 lies next to `tdo`. Capture-DR loads `core_pud`, `core_oe`, `core_out` and `pad_in`.
- R6: Update-DR under external test copies cells c=0..2 of each pin into output latches. While external test is active, `pad_pud`, `pad_oe` and `pad_out` show these latches, starting from the edge that leaves Update-IR. Test reset clears the latches.
- R7: When external test is not active, the pads follow the core signals combinationally, except that `pad_oe` is forced to all zeros while `chip_rst` is high. `core_in` always equals `pad_in`.
- R8: Opcode 0xC selects a one-bit reset stage loaded from `tdi` in Shift-DR. Capture leaves it unchanged. `chip_rst` is the OR of this stage and `sys_rst_in`. Test reset and Test-Logic-Reset clear the stage.
- R9: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high exactly while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Test reset, synchronous, active high |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| core_pud | input | NPIN | Pull-up disable requested by the core |
| core_oe | input | NPIN | Output enable requested by the core |
| core_out | input | NPIN | Output data requested by the core |
| core_in | output | NPIN | Pin levels returned to the core |
| pad_in | input | NPIN | Levels seen at the pads |
| pad_pud | output | NPIN | Pull-up disable to the pads |
| pad_oe | output | NPIN | Output enable to the pads |
| pad_out | output | NPIN | Output data to the pads |
| sys_rst_in | input | 1 | Reset from other sources |
| chip_rst | output | 1 | Internal reset to the core |

## Verification
The bench builds the block with NPIN=3, which gives a 12-cell chain, and with an identity word whose version, part and manufacturer fields are all non-zero. As a result, a swapped field or a misplaced fixed bit shows up in the returned word. Three pins are enough to give each pin a different pattern across its four cell kinds, so a cell-order error or a pin-order error changes both the captured bits and the pads driven after update. The bench scans the instruction register with 0xC, 0xD, 0x5 and 0xF, which covers the reset stage next to its neighbouring unassigned codes and the bypass default.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam int IR_W          = 4;
    localparam int ID_W          = 32;
    localparam int CELLS_PER_PIN = 4;
    localparam int CELL_PUD      = 0;
    localparam int CELL_OE       = 1;
    localparam int CELL_DOUT     = 2;
    localparam int CELL_DIN      = 3;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = 4'h0;
    localparam opcode_t OP_IDCODE  = 4'h1;
    localparam opcode_t OP_RSTREG  = 4'hC;
    localparam opcode_t OP_BYPASS  = 4'hF;
    localparam opcode_t IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {SEL_BYPASS, SEL_ID, SEL_CHAIN, SEL_RST} dr_sel_t;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } scan_ctl_t;

    typedef struct packed {
        logic pud;
        logic oe;
        logic dout;
    } pin_drive_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
        case (s)
            ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  return tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  return tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            default:   return tms ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic dr_sel_t decode_op(input opcode_t op);
        case (op)
            OP_EXTEST: return SEL_CHAIN;
            OP_IDCODE: return SEL_ID;
            OP_RSTREG: return SEL_RST;
            default:   return SEL_BYPASS;
        endcase
    endfunction

    function automatic logic [ID_W-1:0] make_id(input logic [3:0] ver,
                                                input logic [15:0] part,
                                                input logic [10:0] mfr);
        return {ver, part, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm import tap_pkg::*; (
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output scan_ctl_t  ir_ctl,
    output scan_ctl_t  dr_ctl
);
    tap_state_t state_q;

    always_ff @(posedge tck) begin
        if (trst) state_q <= ST_RESET;
        else      state_q <= tap_next(state_q, tms);
    end

    assign state    = state_q;
    assign in_reset = (state_q == ST_RESET);

    always_comb begin
        ir_ctl.capture = (state_q == ST_CAP_IR);
        ir_ctl.shift   = (state_q == ST_SH_IR);
        ir_ctl.update  = (state_q == ST_UPD_IR);
        dr_ctl.capture = (state_q == ST_CAP_DR);
        dr_ctl.shift   = (state_q == ST_SH_DR);
        dr_ctl.update  = (state_q == ST_UPD_DR);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir import tap_pkg::*; (
    input  logic      tck,
    input  logic      trst,
    input  logic      tdi,
    input  logic      in_reset,
    input  scan_ctl_t ctl,
    output opcode_t   ir_q,
    output opcode_t   ir_sh
);
    opcode_t sh_q;
    opcode_t act_q;

    always_ff @(posedge tck) begin
        if (trst || ctl.capture) sh_q <= IR_CAPTURE;
        else if (ctl.shift)      sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (trst || in_reset) act_q <= OP_IDCODE;
        else if (ctl.update)  act_q <= sh_q;
    end

    assign ir_q  = act_q;
    assign ir_sh = sh_q;
endmodule

// File: rtl/tap_dr_bank.sv
module tap_dr_bank import tap_pkg::*; #(
    parameter int              NPIN    = 4,
    parameter logic [ID_W-1:0] ID_WORD = 32'h0000_0001
) (
    input  logic            tck,
    input  logic            trst,
    input  logic            tdi,
    input  logic            in_reset,
    input  scan_ctl_t       ctl,
    input  dr_sel_t         sel,
    input  logic [NPIN-1:0] core_pud,
    input  logic [NPIN-1:0] core_oe,
    input  logic [NPIN-1:0] core_out,
    input  logic [NPIN-1:0] pad_in,
    output logic            dr_lsb,
    output logic            byp_q,
    output logic            rst_q,
    output logic [NPIN-1:0] lat_pud,
    output logic [NPIN-1:0] lat_oe,
    output logic [NPIN-1:0] lat_out
);
    localparam int CHAIN = NPIN * CELLS_PER_PIN;

    logic [ID_W-1:0]  id_q;
    logic [CHAIN-1:0] chain_q;
    logic [CHAIN-1:0] chain_cap;
    logic             byp_r;
    logic             rst_r;

    wire sel_id    = (sel == SEL_ID);
    wire sel_chain = (sel == SEL_CHAIN);
    wire sel_byp   = (sel == SEL_BYPASS);
    wire sel_rst   = (sel == SEL_RST);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pin_drive_t lat_p;

        assign chain_cap[p*CELLS_PER_PIN + CELL_PUD]  = core_pud[p];
        assign chain_cap[p*CELLS_PER_PIN + CELL_OE]   = core_oe[p];
        assign chain_cap[p*CELLS_PER_PIN + CELL_DOUT] = core_out[p];
        assign chain_cap[p*CELLS_PER_PIN + CELL_DIN]  = pad_in[p];

        always_ff @(posedge tck) begin
            if (trst) begin
                lat_p <= '0;
            end else if (ctl.update && sel_chain) begin
                lat_p.pud  <= chain_q[p*CELLS_PER_PIN + CELL_PUD];
                lat_p.oe   <= chain_q[p*CELLS_PER_PIN + CELL_OE];
                lat_p.dout <= chain_q[p*CELLS_PER_PIN + CELL_DOUT];
            end
        end

        assign lat_pud[p] = lat_p.pud;
        assign lat_oe[p]  = lat_p.oe;
        assign lat_out[p] = lat_p.dout;
    end

    always_ff @(posedge tck) begin
        if (trst)                      id_q <= ID_WORD;
        else if (ctl.capture && sel_id) id_q <= ID_WORD;
        else if (ctl.shift && sel_id)   id_q <= {tdi, id_q[ID_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (trst)                          chain_q <= '0;
        else if (ctl.capture && sel_chain) chain_q <= chain_cap;
        else if (ctl.shift && sel_chain)   chain_q <= {tdi, chain_q[CHAIN-1:1]};
    end

    always_ff @(posedge tck) begin
        if (trst || (ctl.capture && sel_byp)) byp_r <= 1'b0;
        else if (ctl.shift && sel_byp)        byp_r <= tdi;
    end

    always_ff @(posedge tck) begin
        if (trst || in_reset)          rst_r <= 1'b0;
        else if (ctl.shift && sel_rst) rst_r <= tdi;
    end

    always_comb begin
        case (sel)
            SEL_ID:    dr_lsb = id_q[0];
            SEL_CHAIN: dr_lsb = chain_q[0];
            SEL_RST:   dr_lsb = rst_r;
            default:   dr_lsb = byp_r;
        endcase
    end

    assign byp_q = byp_r;
    assign rst_q = rst_r;
endmodule

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl import tap_pkg::*; #(
    parameter int          NPIN       = 4,
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h5C31,
    parameter logic [10:0] ID_MFR     = 11'h0A7
) (
    input  logic            tck,
    input  logic            trst,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic [NPIN-1:0] core_pud,
    input  logic [NPIN-1:0] core_oe,
    input  logic [NPIN-1:0] core_out,
    output logic [NPIN-1:0] core_in,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_pud,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    input  logic            sys_rst_in,
    output logic            chip_rst
);
    localparam logic [ID_W-1:0] ID_WORD = make_id(ID_VERSION, ID_PART, ID_MFR);

    tap_state_t      state;
    logic            in_reset;
    scan_ctl_t       ir_ctl;
    scan_ctl_t       dr_ctl;
    opcode_t         ir_q;
    opcode_t         ir_sh;
    dr_sel_t         sel;
    logic            dr_lsb;
    logic            byp_q;
    logic            rst_q;
    logic [NPIN-1:0] lat_pud;
    logic [NPIN-1:0] lat_oe;
    logic [NPIN-1:0] lat_out;
    logic            tdo_q;
    logic            oe_q;

    tap_fsm u_fsm (
        .tck(tck), .trst(trst), .tms(tms),
        .state(state), .in_reset(in_reset), .ir_ctl(ir_ctl), .dr_ctl(dr_ctl)
    );

    tap_ir u_ir (
        .tck(tck), .trst(trst), .tdi(tdi), .in_reset(in_reset),
        .ctl(ir_ctl), .ir_q(ir_q), .ir_sh(ir_sh)
    );

    assign sel = decode_op(ir_q);

    tap_dr_bank #(.NPIN(NPIN), .ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .trst(trst), .tdi(tdi), .in_reset(in_reset),
        .ctl(dr_ctl), .sel(sel),
        .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out), .pad_in(pad_in),
        .dr_lsb(dr_lsb), .byp_q(byp_q), .rst_q(rst_q),
        .lat_pud(lat_pud), .lat_oe(lat_oe), .lat_out(lat_out)
    );

    always_ff @(negedge tck) begin
        if (trst) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q  <= ir_ctl.shift | dr_ctl.shift;
            tdo_q <= ir_ctl.shift ? ir_sh[0] : (dr_ctl.shift ? dr_lsb : 1'b0);
        end
    end

    assign tdo      = tdo_q;
    assign tdo_oe   = oe_q;
    assign chip_rst = sys_rst_in | rst_q;
    assign core_in  = pad_in;

    wire extest = (sel == SEL_CHAIN);

    for (genvar p = 0; p < NPIN; p++) begin : g_mux
        pin_drive_t drv;
        always_comb begin
            if (extest) begin
                drv = '{pud: lat_pud[p], oe: lat_oe[p], dout: lat_out[p]};
            end else begin
                drv = '{pud: core_pud[p], oe: core_oe[p] & ~chip_rst, dout: core_out[p]};
            end
        end
        assign pad_pud[p] = drv.pud;
        assign pad_oe[p]  = drv.oe;
        assign pad_out[p] = drv.dout;
    end
endmodule

// File: rtl/tap_scan_sva.sv
module tap_scan_sva import tap_pkg::*; #(
    parameter int NPIN = 4
) (
    input logic            tck,
    input logic            trst,
    input logic            tms,
    input tap_state_t      state,
    input opcode_t         ir_q,
    input opcode_t         ir_sh,
    input logic            byp_q,
    input logic            chip_rst,
    input logic            sys_rst_in,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] lat_oe,
    input logic            tdo_oe
);
    AST_TLR_LOADS_IDCODE: assert property (@(posedge tck) disable iff (trst)
        (state == ST_RESET) |=> (ir_q == OP_IDCODE)); // R1

    AST_FIVE_TMS_HIGH: assert property (@(posedge tck) disable iff (trst)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_RESET)); // R2

    AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (trst)
        (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE)); // R3

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (trst)
        (state == ST_CAP_DR && decode_op(ir_q) == SEL_BYPASS) |=> !byp_q); // R4

    AST_EXTEST_DRIVES_LATCH: assert property (@(posedge tck) disable iff (trst)
        (ir_q == OP_EXTEST) |-> (pad_oe == lat_oe)); // R6

    AST_RESET_TRISTATE: assert property (@(posedge tck) disable iff (trst)
        (chip_rst && ir_q != OP_EXTEST) |-> (pad_oe == '0)); // R7

    AST_TLR_CLEARS_RSTREG: assert property (@(posedge tck) disable iff (trst)
        (state == ST_RESET) |=> (chip_rst == sys_rst_in)); // R8

    AST_TDO_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (trst)
        tdo_oe == (state == ST_SH_DR || state == ST_SH_IR)); // R9
endmodule

bind tap_scan_ctrl tap_scan_sva #(.NPIN(NPIN)) u_sva (
    .tck(tck), .trst(trst), .tms(tms), .state(state), .ir_q(ir_q), .ir_sh(ir_sh),
    .byp_q(byp_q), .chip_rst(chip_rst), .sys_rst_in(sys_rst_in),
    .pad_oe(pad_oe), .lat_oe(lat_oe), .tdo_oe(tdo_oe)
);

// File: tb/tb_tap_scan_ctrl.sv
`timescale 1ns/1ps
module tb_tap_scan_ctrl;
    localparam int          NPIN  = 3;
    localparam int          CHAIN = NPIN * 4;
    localparam logic [3:0]  VER   = 4'h3;
    localparam logic [15:0] PART  = 16'h9A41;
    localparam logic [10:0] MFR   = 11'h05B;
    localparam logic [31:0] IDW   = {VER, PART, MFR, 1'b1};

    logic tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0, sys_rst_in = 1'b0;
    logic [NPIN-1:0] core_pud = '0, core_oe = '0, core_out = '0, pad_in = '0;
    logic tdo, tdo_oe, chip_rst;
    logic [NPIN-1:0] core_in, pad_pud, pad_oe, pad_out;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 tck = ~tck;

    tap_scan_ctrl #(.NPIN(NPIN), .ID_VERSION(VER), .ID_PART(PART), .ID_MFR(MFR)) dut (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out), .core_in(core_in),
        .pad_in(pad_in), .pad_pud(pad_pud), .pad_oe(pad_oe), .pad_out(pad_out),
        .sys_rst_in(sys_rst_in), .chip_rst(chip_rst)
    );

    // behavioural reference: 0 reset,1 idle,2..8 DR column,9..15 IR column
    int ms = 0, mir = 1;
    bit mrst = 0;
    bit [NPIN-1:0] mlat_pud = '0, mlat_oe = '0, mlat_out = '0;
    bit drq[$];
    bit irq[$];
    bit outq[$];

    function automatic int nxt(int s, bit m);
        case (s)
            0: return m ? 0 : 1;   1: return m ? 2 : 1;
            2: return m ? 9 : 3;   3: return m ? 5 : 4;
            4: return m ? 5 : 4;   5: return m ? 8 : 6;
            6: return m ? 7 : 6;   7: return m ? 8 : 4;
            8: return m ? 2 : 1;   9: return m ? 0 : 10;
            10: return m ? 12 : 11; 11: return m ? 12 : 11;
            12: return m ? 15 : 13; 13: return m ? 14 : 13;
            14: return m ? 15 : 11; default: return m ? 2 : 1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic model_step(input bit m, input bit d);
        if (trst) begin
            ms = 0; mir = 1; mrst = 0;
            mlat_pud = '0; mlat_oe = '0; mlat_out = '0;
            return;
        end
        case (ms)
            0: begin mir = 1; mrst = 0; end
            10: irq = '{1'b1, 1'b0, 1'b0, 1'b0};
            11: begin void'(irq.pop_front()); irq.push_back(d); end
            15: mir = {irq[3], irq[2], irq[1], irq[0]};
            3: begin
                drq.delete();
                if (mir == 1) begin
                    for (int i = 0; i < 32; i++) drq.push_back(IDW[i]);
                end else if (mir == 0) begin
                    for (int p = 0; p < NPIN; p++) begin
                        drq.push_back(core_pud[p]); drq.push_back(core_oe[p]);
                        drq.push_back(core_out[p]); drq.push_back(pad_in[p]);
                    end
                end else if (mir == 12) drq.push_back(mrst);
                else drq.push_back(1'b0);
            end
            4: begin
                void'(drq.pop_front()); drq.push_back(d);
                if (mir == 12) mrst = d;
            end
            8: if (mir == 0) begin
                for (int p = 0; p < NPIN; p++) begin
                    mlat_pud[p] = drq[4*p]; mlat_oe[p] = drq[4*p+1]; mlat_out[p] = drq[4*p+2];
                end
            end
            default: ;
        endcase
        ms = nxt(ms, m);
    endtask

    task automatic compare();
        bit eoe, ecr;
        bit [NPIN-1:0] epud, eoen, eout;
        string dtag;
        eoe = (ms == 4 || ms == 11);
        chk("R9 tdo_oe", 64'(tdo_oe), 64'(eoe));
        if (ms == 11) chk("R3 tdo in IR shift", 64'(tdo), 64'(irq[0]));
        if (ms == 4) begin
            dtag = (mir == 1) ? "R1 tdo id" : (mir == 0) ? "R5 tdo chain" :
                   (mir == 12) ? "R8 tdo reset stage" : "R4 tdo bypass";
            chk(dtag, 64'(tdo), 64'(drq[0]));
        end
        if (eoe) outq.push_back(tdo);
        ecr = sys_rst_in | mrst;
        chk("R8 chip_rst", 64'(chip_rst), 64'(ecr));
        if (mir == 0) begin
            epud = mlat_pud; eoen = mlat_oe; eout = mlat_out;
        end else begin
            epud = core_pud; eoen = ecr ? '0 : core_oe; eout = core_out;
        end
        chk((mir == 0) ? "R6 pads" : "R7 pads", 64'({pad_pud, pad_oe, pad_out}),
            64'({epud, eoen, eout}));
        chk("R7 core_in", 64'(core_in), 64'(pad_in));
    endtask

    task automatic tick(input bit m, input bit d);
        tms = m; tdi = d;
        @(posedge tck);
        cyc++;
        model_step(m, d);
        @(negedge tck);
        #1;
        compare();
    endtask

    // from Run-Test/Idle, back to Run-Test/Idle
    task automatic scan_ir(input logic [3:0] code, output logic [3:0] got);
        outq.delete();
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) tick(i == 3, code[i]);
        tick(1, 0); tick(0, 0);
        got = '0;
        for (int i = 0; i < 4; i++) got[i] = outq[i];
    endtask

    task automatic scan_dr(input logic [63:0] bits, input int n, output logic [63:0] got);
        outq.delete();
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) tick(i == n - 1, bits[i]);
        tick(1, 0); tick(0, 0);
        got = '0;
        for (int i = 0; i < n; i++) got[i] = outq[i];
    endtask

    initial begin
        logic [3:0]  ig;
        logic [63:0] g;
        logic [63:0] pat;
        logic [CHAIN-1:0] cap;

        for (int i = 0; i < 3; i++) tick(1, 0);
        trst = 1'b0;
        chk("R9 tdo_oe low after reset", 64'(tdo_oe), 64'd0);
        chk("R8 chip_rst low after reset", 64'(chip_rst), 64'd0);
        tick(0, 0);

        scan_dr(64'h0, 32, g);
        chk("R1 idcode after reset", g[31:0], 64'(IDW));
        chk("R1 id bit0 set", 64'(g[0]), 64'd1);

        scan_ir(4'h0, ig);
        chk("R3 IR capture pattern", 64'(ig), 64'h1);
        for (int i = 0; i < 5; i++) tick(1, 0);
        tick(0, 0);
        scan_dr(64'h0, 32, g);
        chk("R2 five tms high restores IDCODE", g[31:0], 64'(IDW));

        scan_ir(4'hF, ig);
        pat = 64'hB2;
        scan_dr(pat, 8, g);
        chk("R4 bypass 0xF delays one bit", g[7:0], 64'({pat[6:0], 1'b0}));
        scan_ir(4'h5, ig);
        scan_dr(64'h5A, 8, g);
        chk("R4 bypass 0x5", g[7:0], 64'({8'h5A} << 1) & 64'hFF);
        scan_ir(4'hD, ig);
        scan_dr(64'hC3, 8, g);
        chk("R4 bypass 0xD", g[7:0], 64'({8'hC3} << 1) & 64'hFF);

        // data scan through Pause-DR and Exit2-DR under bypass
        tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 1); tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0);
        tick(0, 1); tick(1, 0); tick(1, 0); tick(0, 0);
        chk("R2 pause path returns to idle", 64'(tdo_oe), 64'd0);

        core_pud = 3'b101; core_oe = 3'b011; core_out = 3'b110; pad_in = 3'b010;
        tick(0, 0);
        scan_ir(4'h0, ig);
        chk("R6 latches drive pads once EXTEST loaded", 64'(pad_oe), 64'd0);
        cap = '0;
        for (int p = 0; p < NPIN; p++)
            cap[4*p +: 4] = {pad_in[p], core_out[p], core_oe[p], core_pud[p]};
        pat = 64'h6C5;
        scan_dr(pat, CHAIN, g);
        chk("R5 chain capture order", g[CHAIN-1:0], 64'(cap));
        chk("R6 pad_pud from chain", 64'(pad_pud), 64'({pat[8], pat[4], pat[0]}));
        chk("R6 pad_oe from chain", 64'(pad_oe), 64'({pat[9], pat[5], pat[1]}));
        chk("R6 pad_out from chain", 64'(pad_out), 64'({pat[10], pat[6], pat[2]}));
        scan_dr(64'h93A, CHAIN, g);
        chk("R5 chain returns previous contents", g[CHAIN-1:0], 64'(cap));

        scan_ir(4'hC, ig);
        scan_dr(64'h1, 1, g);
        chk("R8 reset stage initially 0", 64'(g[0]), 64'd0);
        chk("R8 chip_rst set by stage", 64'(chip_rst), 64'd1);
        scan_ir(4'hF, ig);
        chk("R7 outputs tri-stated under reset", 64'(pad_oe), 64'd0);
        scan_ir(4'hC, ig);
        scan_dr(64'h0, 1, g);
        chk("R8 reset stage held 1 over capture", 64'(g[0]), 64'd1);
        chk("R8 chip_rst released", 64'(chip_rst), 64'd0);
        chk("R7 pads follow core", 64'(pad_oe), 64'(core_oe));
        sys_rst_in = 1'b1;
        tick(0, 0);
        chk("R8 other reset source", 64'(chip_rst), 64'd1);
        sys_rst_in = 1'b0;
        scan_dr(64'h1, 1, g);
        for (int i = 0; i < 5; i++) tick(1, 0);
        tick(0, 0);
        chk("R8 test-logic-reset clears stage", 64'(chip_rst), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule